// File: doc/BRIEF.md
# DMA Step Response and Error Handler

This block sits beside a DMA channel and judges each transfer step. When the channel presents a step result, the block compares the source and destination addresses with their bus widths. It also looks at the bus error flags and at the active descriptor's control bits. From these it forms one 3-bit response code, and it applies the side effects that belong to that code. A sticky interrupt cause bit may be raised. The descriptor may receive a one-cycle invalidate pulse. The channel may be switched off. The current-descriptor selector may be toggled.

The channel is armed by a start pulse. Each step is reported by a one-cycle `step_vld` strobe, and `step_last` marks the step that completes the descriptor. Software clears the interrupt causes with a write-one-to-clear strobe. The block does not fetch descriptors and does not run bus transactions. It only judges their outcome.

Top module: `dma_resp_unit`

## Requirements
- R1: After reset `resp_vld`, `chan_en`, `cur_sel`, `dsc_inval` and all `irq_cause` bits are 0.
- R2: A step strobe taken while `chan_en` is 1 yields `resp_vld`=1 for exactly the next cycle. The code appears on `resp_code` in that cycle, with encoding 0 no error, 1 done, 2 source bus error, 3 destination bus error, 4 source misaligned, 5 destination misaligned, 6 invalid descriptor. A step with no fault gives 1 when `step_last` is 1 and 0 otherwise.
- R3: Size encoding is 0 byte, 1 halfword, 2 or 3 word. A halfword access is misaligned when address bit 0 is 1. A word access is misaligned when address bit 0 or bit 1 is 1. A byte access is never misaligned. Source and destination are checked separately.
- R4: When several faults coincide, the code picks invalid descriptor first, then source misaligned, destination misaligned, source bus error, and destination bus error.
- R5: Code 0 raises no cause bit, gives no invalidate pulse, and leaves `chan_en` and `cur_sel` unchanged.
- R6: Code 1 sets cause bit 0 only if `dsc_irq` is 1. It pulses `dsc_inval` only if `dsc_inv_done` is 1. It toggles `cur_sel` only if `dsc_flip` is 1. It keeps `chan_en` at 1.
- R7: Codes 2 to 5 set cause bit (code-1), pulse `dsc_inval`, clear `chan_en`, and leave `cur_sel` unchanged.
- R8: Code 6 clears `chan_en`. It raises no cause bit, gives no invalidate pulse, and leaves `cur_sel` unchanged.
- R9: Cause bits are sticky. A bit falls only in the cycle after its `irq_clr` bit was 1.
- R10: `chan_on` sets `chan_en` on the next edge. A step strobe while `chan_en` is 0 is ignored, so no response, cause, invalidate or selector change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_on | input | 1 | Channel start pulse |
| step_vld | input | 1 | Step result strobe |
| step_last | input | 1 | Step completes the descriptor |
| src_addr | input | AW | Source address |
| src_size | input | 2 | Source bus width code |
| dst_addr | input | AW | Destination address |
| dst_size | input | 2 | Destination bus width code |
| src_berr | input | 1 | Source bus error |
| dst_berr | input | 1 | Destination bus error |
| dsc_valid | input | 1 | Descriptor valid bit |
| dsc_irq | input | 1 | Descriptor interrupt enable |
| dsc_inv_done | input | 1 | Invalidate on completion |
| dsc_flip | input | 1 | Switch descriptor on completion |
| irq_clr | input | 5 | Write-one-to-clear for cause bits |
| resp_vld | output | 1 | Response valid |
| resp_code | output | 3 | Response code |
| irq_cause | output | 5 | Sticky cause bits, bit k for code k+1 |
| dsc_inval | output | 1 | Descriptor invalidate pulse |
| chan_en | output | 1 | Channel enable state |
| cur_sel | output | 1 | Current descriptor selector |

## Verification
The bench aims at priority collisions: an invalid descriptor with misalignment and a bus error, and both misalignments with both bus errors. A wrong priority chain would report the lower fault instead. It drives byte accesses on odd addresses and halfword accesses on addresses that are 2 mod 4. A checker that ignored the width would report false misalignments there. It also checks done steps with every control bit clear. An effect decoder that did not honour those bits would still raise an interrupt, invalidate the descriptor or flip the selector. Strobes on a stopped channel, and partial clears of sticky causes, expose designs that act without an enabled channel or that clear the wrong bits.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;

   typedef enum logic [2:0] {
      RC_OK       = 3'd0,
      RC_DONE     = 3'd1,
      RC_SRC_BUS  = 3'd2,
      RC_DST_BUS  = 3'd3,
      RC_SRC_MIS  = 3'd4,
      RC_DST_MIS  = 3'd5,
      RC_BAD_DSC  = 3'd6
   } resp_t;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WRSV = 2'd3
   } size_t;

   localparam int unsigned NUM_CAUSE = 5;

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk
   import dma_resp_pkg::*;
#(
   parameter int unsigned AW = 32
)(
   input  logic [AW-1:0] addr,
   input  size_t         size,
   output logic          misal
);

   if (AW < 2) begin : g_bad_aw
      $error("dma_align_chk: AW must be at least 2");
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: misal = 1'b0;
         SZ_HALF: misal = addr[0];
         default: misal = |addr[1:0];
      endcase
   end

endmodule

// File: rtl/dma_resp_prio.sv
module dma_resp_prio
   import dma_resp_pkg::*;
(
   input  logic  dsc_ok,
   input  logic  src_mis,
   input  logic  dst_mis,
   input  logic  src_bus,
   input  logic  dst_bus,
   input  logic  last,
   output resp_t code
);

   always_comb begin
      if (!dsc_ok)      code = RC_BAD_DSC;
      else if (src_mis) code = RC_SRC_MIS;
      else if (dst_mis) code = RC_DST_MIS;
      else if (src_bus) code = RC_SRC_BUS;
      else if (dst_bus) code = RC_DST_BUS;
      else if (last)    code = RC_DONE;
      else              code = RC_OK;
   end

endmodule

// File: rtl/dma_resp_effects.sv
module dma_resp_effects
   import dma_resp_pkg::*;
#(
   parameter int unsigned NC = NUM_CAUSE
)(
   input  resp_t         code,
   input  logic          irq_en,
   input  logic          inv_done,
   input  logic          flip,
   output logic [NC-1:0] cause_set,
   output logic          inval,
   output logic          halt,
   output logic          toggle
);

   localparam logic [2:0] LAST_ERR = 3'(NC);

   for (genvar i = 0; i < NC; i++) begin : g_cause
      if (i == 0) begin : g_done
         assign cause_set[i] = (code == RC_DONE) && irq_en;
      end else begin : g_err
         assign cause_set[i] = (code == resp_t'(3'(i + 1)));
      end
   end

   logic is_err;
   assign is_err = (code >= RC_SRC_BUS) && (code <= LAST_ERR);

   assign inval  = is_err || ((code == RC_DONE) && inv_done);
   assign halt   = is_err || (code == RC_BAD_DSC);
   assign toggle = (code == RC_DONE) && flip;

endmodule

// File: rtl/dma_resp_unit.sv
module dma_resp_unit
   import dma_resp_pkg::*;
#(
   parameter int unsigned AW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_on,
   input  logic          step_vld,
   input  logic          step_last,
   input  logic [AW-1:0] src_addr,
   input  logic [1:0]    src_size,
   input  logic [AW-1:0] dst_addr,
   input  logic [1:0]    dst_size,
   input  logic          src_berr,
   input  logic          dst_berr,
   input  logic          dsc_valid,
   input  logic          dsc_irq,
   input  logic          dsc_inv_done,
   input  logic          dsc_flip,
   input  logic [4:0]    irq_clr,
   output logic          resp_vld,
   output logic [2:0]    resp_code,
   output logic [4:0]    irq_cause,
   output logic          dsc_inval,
   output logic          chan_en,
   output logic          cur_sel
);

   localparam int unsigned NC = NUM_CAUSE;

   if (NC != 5) begin : g_bad_nc
      $error("dma_resp_unit: cause vector width mismatch");
   end

   logic    s_mis, d_mis;
   resp_t   code;
   logic [NC-1:0] c_set;
   logic    e_inval, e_halt, e_tog;
   logic    take;

   assign take = step_vld && chan_en;

   dma_align_chk #(.AW(AW)) u_src_al (
      .addr (src_addr),
      .size (size_t'(src_size)),
      .misal(s_mis)
   );

   dma_align_chk #(.AW(AW)) u_dst_al (
      .addr (dst_addr),
      .size (size_t'(dst_size)),
      .misal(d_mis)
   );

   dma_resp_prio u_prio (
      .dsc_ok (dsc_valid),
      .src_mis(s_mis),
      .dst_mis(d_mis),
      .src_bus(src_berr),
      .dst_bus(dst_berr),
      .last   (step_last),
      .code   (code)
   );

   dma_resp_effects #(.NC(NC)) u_fx (
      .code     (code),
      .irq_en   (dsc_irq),
      .inv_done (dsc_inv_done),
      .flip     (dsc_flip),
      .cause_set(c_set),
      .inval    (e_inval),
      .halt     (e_halt),
      .toggle   (e_tog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_vld  <= 1'b0;
         resp_code <= 3'd0;
         dsc_inval <= 1'b0;
         chan_en   <= 1'b0;
         cur_sel   <= 1'b0;
      end else begin
         resp_vld  <= take;
         dsc_inval <= take && e_inval;
         if (take) begin
            resp_code <= code;
         end
         if (take && e_halt) begin
            chan_en <= 1'b0;
         end else if (chan_on) begin
            chan_en <= 1'b1;
         end
         if (take && e_tog) begin
            cur_sel <= ~cur_sel;
         end
      end
   end

   for (genvar k = 0; k < NC; k++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_cause[k] <= 1'b0;
         end else if (take && c_set[k]) begin
            irq_cause[k] <= 1'b1;
         end else if (irq_clr[k]) begin
            irq_cause[k] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dma_resp_unit_chk.sv
module dma_resp_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       step_vld,
   input logic       chan_en,
   input logic       resp_vld,
   input logic [2:0] resp_code,
   input logic       dsc_inval,
   input logic       cur_sel,
   input logic [4:0] irq_cause,
   input logic [4:0] irq_clr
);

   a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (step_vld && chan_en) |=> resp_vld);

   a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_vld && chan_en) |=> !resp_vld);

   a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld |-> (resp_code <= 3'd6));

   a_r7_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_vld && resp_code >= 3'd2) |-> !chan_en);

   a_r8_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_vld && resp_code == 3'd6) |-> !dsc_inval);

   a_r5_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_vld && resp_code != 3'd1) |-> $stable(cur_sel));

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((~irq_cause & $past(irq_cause) & ~$past(irq_clr)) == 5'd0));

   a_r10_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_inval |-> resp_vld);

endmodule

bind dma_resp_unit dma_resp_unit_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_vld (step_vld),
   .chan_en  (chan_en),
   .resp_vld (resp_vld),
   .resp_code(resp_code),
   .dsc_inval(dsc_inval),
   .cur_sel  (cur_sel),
   .irq_cause(irq_cause),
   .irq_clr  (irq_clr)
);

// File: tb/dma_resp_unit_bench.sv
module dma_resp_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_on = 1'b0, step_vld = 1'b0, step_last = 1'b0;
   logic [31:0] src_addr = '0, dst_addr = '0;
   logic [1:0]  src_size = '0, dst_size = '0;
   logic        src_berr = 1'b0, dst_berr = 1'b0;
   logic        dsc_valid = 1'b1, dsc_irq = 1'b0, dsc_inv_done = 1'b0, dsc_flip = 1'b0;
   logic [4:0]  irq_clr = '0;
   logic        resp_vld, dsc_inval, chan_en, cur_sel;
   logic [2:0]  resp_code;
   logic [4:0]  irq_cause;

   int total = 0;
   int bad = 0;
   logic model_sel = 1'b0;

   always #2 clk = ~clk;

   dma_resp_unit u_dma_resp_unit (
      .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .step_vld(step_vld),
      .step_last(step_last), .src_addr(src_addr), .src_size(src_size),
      .dst_addr(dst_addr), .dst_size(dst_size), .src_berr(src_berr),
      .dst_berr(dst_berr), .dsc_valid(dsc_valid), .dsc_irq(dsc_irq),
      .dsc_inv_done(dsc_inv_done), .dsc_flip(dsc_flip), .irq_clr(irq_clr),
      .resp_vld(resp_vld), .resp_code(resp_code), .irq_cause(irq_cause),
      .dsc_inval(dsc_inval), .chan_en(chan_en), .cur_sel(cur_sel)
   );

   // last, saddr[3:0], ssz, daddr[3:0], dsz, sberr, dberr, valid, irq, inv, flip, expected code
   localparam int NV = 14;
   localparam logic [23:0] VEC [NV] = '{
      {1'b0, 4'h0, 2'd2, 4'h4, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
      {1'b1, 4'h0, 2'd2, 4'h8, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1},
      {1'b1, 4'h4, 2'd1, 4'h2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1},
      {1'b1, 4'h0, 2'd2, 4'h0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2},
      {1'b0, 4'h0, 2'd0, 4'h0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
      {1'b0, 4'h1, 2'd1, 4'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4},
      {1'b0, 4'h2, 2'd2, 4'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4},
      {1'b1, 4'h0, 2'd2, 4'h1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5},
      {1'b1, 4'h1, 2'd0, 4'h3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1},
      {1'b1, 4'h1, 2'd1, 4'h0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd6},
      {1'b0, 4'h1, 2'd1, 4'h2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4},
      {1'b0, 4'h0, 2'd2, 4'h3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5},
      {1'b1, 4'h0, 2'd2, 4'h0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
      {1'b0, 4'h2, 2'd1, 4'h6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_chan();
      @(negedge clk); chan_on = 1'b1; irq_clr = 5'h1f;
      @(negedge clk); chan_on = 1'b0; irq_clr = 5'h00;
   endtask

   task automatic do_step();
      @(negedge clk); step_vld = 1'b1;
      @(negedge clk); step_vld = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [2:0] ec;
      logic [4:0] eirq;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 resp_vld", resp_vld, 0);
      check("R1 chan_en", chan_en, 0);
      check("R1 cur_sel", cur_sel, 0);
      check("R1 irq_cause", irq_cause, 0);
      check("R1 dsc_inval", dsc_inval, 0);
      rst_n = 1'b1;

      // R10 step ignored while channel is off
      step_last = 1'b1; dsc_irq = 1'b1; dsc_inv_done = 1'b1; dsc_flip = 1'b1;
      do_step();
      check("R10 no resp when off", resp_vld, 0);
      check("R10 no inval when off", dsc_inval, 0);
      check("R10 no irq when off", irq_cause, 0);
      check("R10 sel kept when off", cur_sel, 0);

      // table walk: R2..R8
      for (int i = 0; i < NV; i++) begin
         start_chan();
         check("R10 chan_on enables", chan_en, 1);
         {step_last, src_addr[3:0], src_size, dst_addr[3:0], dst_size, src_berr,
          dst_berr, dsc_valid, dsc_irq, dsc_inv_done, dsc_flip, ec} = VEC[i];
         do_step();
         eirq = '0;
         if (ec == 3'd1 && dsc_irq) eirq[0] = 1'b1;
         if (ec >= 3'd2 && ec <= 3'd5) eirq[ec - 3'd1] = 1'b1;
         if (ec == 3'd1 && dsc_flip) model_sel = ~model_sel;
         check("R2 resp_vld", resp_vld, 1);
         check("R2/R3/R4 resp_code", resp_code, ec);
         check("R5/R6/R7/R8 irq_cause", irq_cause, eirq);
         check("R5/R6/R7/R8 dsc_inval", dsc_inval,
               (ec >= 3'd2 && ec <= 3'd5) || (ec == 3'd1 && dsc_inv_done));
         check("R5/R6/R7/R8 chan_en", chan_en, (ec <= 3'd1));
         check("R5/R6/R7/R8 cur_sel", cur_sel, model_sel);
         @(negedge clk);
         check("R2 single cycle resp", resp_vld, 0);
      end

      // R9 sticky causes and selective clear
      start_chan();
      {step_last, src_berr, dst_berr, dsc_valid, dsc_irq, dsc_flip} = 6'b110110;
      src_addr = '0; dst_addr = '0; src_size = 2'd2; dst_size = 2'd2;
      do_step();
      start_chan(); // clears all, re-arms
      check("R9 clear all", irq_cause, 0);
      dsc_irq = 1'b1; step_last = 1'b1; src_berr = 1'b0; dst_berr = 1'b0; dsc_flip = 1'b0;
      do_step();                       // done -> bit0
      src_berr = 1'b1;
      do_step();                       // src bus -> bit1, channel stops
      repeat (3) @(negedge clk);
      check("R9 sticky held", irq_cause, 5'b00011);
      @(negedge clk); irq_clr = 5'b00010;
      @(negedge clk); irq_clr = 5'b00000;
      check("R9 selective clear", irq_cause, 5'b00001);
      check("R7 channel off after error", chan_en, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule